// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block watches a processor for signs of a hang. A counter advances on every cycle where the processor E-clock enable is high. If software does not service the block before the selected interval runs out, the block raises a one-cycle timeout. A reset controller or a failure handler uses this pulse to reset the processor or to start a recovery routine. Software services the block by writing two key bytes in a fixed order to a service register: first 0x55, then 0xAA. No other write restarts the interval, so a runaway program that scribbles over the register space is unlikely to keep the timer quiet by accident.

Software sets up the block through two more byte registers on the same write port. A configuration register holds a disable bit, which is clear after reset, so the watchdog starts out running. An option register holds a two-bit rate code that picks one of four power-of-two interval lengths. The block latches the rate code each time the interval restarts. A rate write made mid-interval therefore applies to the next interval.

Top module: `keyed_watchdog`

## Requirements
- R1: Writing bit 2 of the configuration register (address 0x003F) as 1 disables the watchdog. While it is disabled no timeout occurs and the counter and the armed state are held clear. Writing the bit as 0 enables the watchdog, and the counter starts from zero at that write.
- R2: Bits 1:0 of the option register (address 0x0039) hold the rate code used for the interval.
- R3: The interval is 2^(MIN_LOG2+3-rate) enabled cycles. With the default MIN_LOG2 of 13, rate 0 gives 2^16, rate 1 gives 2^15, rate 2 gives 2^14 and rate 3 gives 2^13.
- R4: The counter advances only on clock edges where ce_i is high. An edge with ce_i low does not shorten the interval.
- R5: timeout_o is high for exactly one cycle, in the cycle after the edge that ends the interval. The counter then restarts from zero, so timeouts recur every interval while the watchdog is not serviced.
- R6: Writing 0x55 and then 0xAA to the service register (address 0x003A) restarts the interval at the 0xAA write. Writing 0xAA without a preceding 0x55 leaves the counter unchanged.
- R7: After 0x55, a write of any value other than 0xAA or 0x55 to the service register cancels the armed state and leaves the counter unchanged.
- R8: A new rate code applies from the next interval restart. An interval that is already running keeps its length.
- R9: A synchronous active-high rst clears the counter, the armed state and the rate code, and clears the disable bit. The watchdog runs at rate 0 from the first edge after reset.
- R10: If a valid service lands on the same edge that would end the interval, the service wins and no timeout is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | E-clock enable; the counter advances on edges where it is high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register write address |
| wdata_i | input | 8 | Register write data |
| timeout_o | output | 1 | One-cycle timeout / reset request |

## Verification
A write counts on the edge where the strobe is sampled. A service write restarts the counter on that edge. The timeout then appears in the cycle that follows the L-th later enabled edge, where L is the selected interval, plus one extra edge for each cycle that ce_i was held low. The bench drives inputs on falling edges and samples on falling edges. After each service or configuration write it counts falling edges until timeout_o rises, and compares that count with the interval computed from the rate code, the ce_i gap, and the cycles spent since the restarting write. For the collision case the bench places the 0xAA write exactly on the expiry edge and checks that timeout_o stays low in the following cycle.

// File: rtl/keyed_wd_pkg.sv
package keyed_wd_pkg;

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;

    localparam int DIS_BIT = 2;

    typedef struct packed {
        logic       off;
        logic [1:0] rate;
    } wd_cfg_t;

    typedef enum logic {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } key_state_e;

    // Last count value of an interval of 2^(min_log2+3-rate) enabled cycles.
    function automatic logic [31:0] terminal_count(input int unsigned min_log2,
                                                   input logic [1:0]  rate);
        return (32'd1 << (min_log2 + 32'd3 - 32'(rate))) - 32'd1;
    endfunction

endpackage

// File: rtl/keyed_wd_regs.sv
module keyed_wd_regs
    import keyed_wd_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h003F,
    parameter logic [ADDR_W-1:0] OPT_ADDR = 16'h0039,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 16'h003A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output wd_cfg_t           cfg,
    output logic              svc_wr
);

    wd_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            if (addr == CFG_ADDR) cfg_q.off  <= wdata[DIS_BIT];
            if (addr == OPT_ADDR) cfg_q.rate <= wdata[1:0];
        end
    end

    assign cfg    = cfg_q;
    assign svc_wr = wr_en && (addr == SVC_ADDR);

endmodule

// File: rtl/keyed_wd_keyseq.sv
module keyed_wd_keyseq
    import keyed_wd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       svc_wr,
    input  logic [7:0] wdata,
    output logic       armed,
    output logic       restart
);

    key_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= KS_IDLE;
        end else if (svc_wr) begin
            state_q <= (wdata == KEY_ARM) ? KS_ARMED : KS_IDLE;
        end
    end

    assign armed   = (state_q == KS_ARMED);
    assign restart = en && svc_wr && armed && (wdata == KEY_FIRE);

endmodule

// File: rtl/keyed_wd_counter.sv
module keyed_wd_counter
    import keyed_wd_pkg::*;
#(
    parameter int MIN_LOG2 = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       ce,
    input  logic       restart,
    input  logic [1:0] rate,
    output logic       expire
);

    localparam int CNT_W = MIN_LOG2 + 3;

    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       lim_q;
    logic [CNT_W-1:0] term;
    logic             tmo_q;

    assign term = CNT_W'(terminal_count(MIN_LOG2, lim_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= '0;
            tmo_q <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            lim_q <= rate;
            tmo_q <= 1'b0;
        end else begin
            tmo_q <= 1'b0;
            if (restart) begin
                cnt_q <= '0;
                lim_q <= rate;
            end else if (ce) begin
                if (cnt_q == term) begin
                    cnt_q <= '0;
                    lim_q <= rate;
                    tmo_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign expire = tmo_q;

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import keyed_wd_pkg::*;
#(
    parameter int          MIN_LOG2 = 13,
    parameter int          ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h003F,
    parameter logic [ADDR_W-1:0] OPT_ADDR = 16'h0039,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 16'h003A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic              timeout_o
);

    wd_cfg_t cfg;
    logic    svc_wr;
    logic    key_armed;
    logic    svc_restart;
    logic    wd_on;

    assign wd_on = !cfg.off;

    keyed_wd_regs #(
        .ADDR_W  (ADDR_W),
        .CFG_ADDR(CFG_ADDR),
        .OPT_ADDR(OPT_ADDR),
        .SVC_ADDR(SVC_ADDR)
    ) regs_i (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en_i),
        .addr  (addr_i),
        .wdata (wdata_i),
        .cfg   (cfg),
        .svc_wr(svc_wr)
    );

    keyed_wd_keyseq key_i (
        .clk    (clk),
        .rst    (rst),
        .en     (wd_on),
        .svc_wr (svc_wr),
        .wdata  (wdata_i),
        .armed  (key_armed),
        .restart(svc_restart)
    );

    keyed_wd_counter #(
        .MIN_LOG2(MIN_LOG2)
    ) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .en     (wd_on),
        .ce     (ce_i),
        .restart(svc_restart),
        .rate   (cfg.rate),
        .expire (timeout_o)
    );

endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
    parameter int          ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 16'h003A
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [7:0]        wdata_i,
    input logic              timeout_o,
    input logic              wd_off,
    input logic              armed,
    input logic              restart
);

    logic svc_hit;
    assign svc_hit = wr_en_i && (addr_i == SVC_ADDR);

    a_r5_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

    a_r1_silent_when_off: assert property (@(posedge clk) disable iff (rst)
        $past(wd_off) |-> !timeout_o);

    a_r4_needs_enable: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> $past(ce_i));

    a_r6_arm_on_first_key: assert property (@(posedge clk) disable iff (rst)
        (svc_hit && !wd_off && wdata_i == 8'h55) |=> armed);

    a_r7_other_value_disarms: assert property (@(posedge clk) disable iff (rst)
        (svc_hit && wdata_i != 8'h55) |=> !armed);

    a_r10_service_beats_expiry: assert property (@(posedge clk) disable iff (rst)
        restart |=> !timeout_o);

    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !timeout_o);

endmodule

bind keyed_watchdog keyed_watchdog_chk #(
    .ADDR_W  (ADDR_W),
    .SVC_ADDR(SVC_ADDR)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ce_i     (ce_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .timeout_o(timeout_o),
    .wd_off   (cfg.off),
    .armed    (key_armed),
    .restart  (svc_restart)
);

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;

    localparam int MIN_LOG2 = 4;
    localparam logic [15:0] CFG_A = 16'h003F;
    localparam logic [15:0] OPT_A = 16'h0039;
    localparam logic [15:0] SVC_A = 16'h003A;

    localparam int RATE_V [4] = '{0, 1, 2, 3};
    localparam int LEN_V  [4] = '{128, 64, 32, 16};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_i = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic        timeout_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    keyed_watchdog #(.MIN_LOG2(MIN_LOG2)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .ce_i     (ce_i),
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .timeout_o(timeout_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write is sampled at the next rising edge.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic service();
        wr(SVC_A, 8'h55);
        wr(SVC_A, 8'hAA);
    endtask

    // Count falling edges until timeout_o is seen; ce_i is low for the first gap edges.
    task automatic measure(input int gap, output int n);
        n = 0;
        forever begin
            ce_i = (n >= gap);
            @(negedge clk);
            n++;
            if (timeout_o || n > 4000) break;
        end
        ce_i = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        bit seen;
        repeat (3) @(negedge clk);
        check(timeout_o == 1'b0, "R9 reset output", timeout_o, 0);
        rst = 1'b0;

        // R9: runs at rate 0 from reset release
        measure(0, n);
        check(n == 128, "R9 first interval after reset", n, 128);

        // R2 R3 R5: table of rate codes
        foreach (RATE_V[i]) begin
            wr(OPT_A, 8'(RATE_V[i]));
            service();
            measure(0, n);
            check(n == LEN_V[i], "R3 interval for rate", n, LEN_V[i]);
            measure(0, n);
            check(n == LEN_V[i], "R5 recurring timeout", n, LEN_V[i]);
            @(negedge clk);
            check(timeout_o == 1'b0, "R5 single-cycle pulse", timeout_o, 0);
        end

        // rate 1 (64) for the directed tests below
        wr(OPT_A, 8'h01);
        service();
        repeat (5) @(negedge clk);
        wr(SVC_A, 8'hAA);
        measure(0, n);
        check(n == 58, "R6 lone 0xAA no restart", n, 58);

        service();
        repeat (5) @(negedge clk);
        wr(SVC_A, 8'h55);
        wr(SVC_A, 8'h12);
        wr(SVC_A, 8'hAA);
        measure(0, n);
        check(n == 56, "R7 other value disarms", n, 56);

        service();
        repeat (5) @(negedge clk);
        service();
        measure(0, n);
        check(n == 64, "R6 valid pair restarts", n, 64);

        // R4: ce_i low for 10 edges stretches the interval
        service();
        measure(10, n);
        check(n == 74, "R4 enable-gated count", n, 74);

        // R8: rate change mid-interval
        service();
        wr(OPT_A, 8'h03);
        measure(0, n);
        check(n == 63, "R8 running interval kept", n, 63);
        measure(0, n);
        check(n == 16, "R8 new rate next interval", n, 16);

        // R10: service on the expiry edge (interval 16)
        repeat (14) @(negedge clk);
        wr(SVC_A, 8'h55);
        wr(SVC_A, 8'hAA);
        check(timeout_o == 1'b0, "R10 service beats expiry", timeout_o, 0);
        measure(0, n);
        check(n == 16, "R10 interval after collision", n, 16);

        // R1: disable, no timeouts, then re-enable from zero
        wr(CFG_A, 8'h04);
        seen = 1'b0;
        repeat (300) begin
            @(negedge clk);
            if (timeout_o) seen = 1'b1;
        end
        check(seen == 1'b0, "R1 disabled no timeout", seen, 0);
        wr(CFG_A, 8'h00);
        measure(0, n);
        check(n == 16, "R1 re-enable starts from zero", n, 16);

        // R1: armed state cleared while disabled
        wr(SVC_A, 8'h55);
        wr(CFG_A, 8'h04);
        wr(CFG_A, 8'h00);
        wr(SVC_A, 8'hAA);
        measure(0, n);
        check(n == 15, "R1 armed cleared when off", n, 15);

        // R9: reset re-enables and restores rate 0
        wr(CFG_A, 8'h04);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(timeout_o == 1'b0, "R9 output after reset", timeout_o, 0);
        measure(0, n);
        check(n == 128, "R9 reset enables at rate 0", n, 128);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule